// File: doc/BRIEF.md
# Attribute Index Generator

This block turns the linear index of a dispatched thread into the element index used to fetch a per-vertex or per-instance attribute. Each request carries a 32-bit linear index, a 2-bit mode, a 5-bit shift amount, a 3-bit flag field and a 32-bit multiplier. The block returns one 32-bit element index per request. Four modes are supported: the index passes straight through; the index is reduced modulo an odd factor times a power of two; the index is divided by a power of two; or the index is divided by an arbitrary constant using a multiply-high with a fixed-exponent multiplier.

The unit is a three-stage pipeline. Requests enter with a valid/ready handshake and leave in order with a valid/ready handshake. When the consumer stalls, the whole pipeline freezes. The constants (odd factor, shift, multiplier and correction flag) are prepared by software elsewhere. This block only applies them.

Top module: `attr_index_gen`

## Requirements
- R1: With mode code 0 the output equals the input index unchanged.
- R2: With mode code 1 the output equals index mod ((2·m+1)·2^s), where m is the full 3-bit flag field (all eight values, giving odd factors 1 to 15) and s is the shift field. No bits above the modulus survive, and the low s bits of the index are kept as they are.
- R3: With mode code 2 the output equals the index shifted right by s (a logical shift, 0 to 31).
- R4: With mode code 3 the multiplier M' is the supplied multiplier with its top bit forced to 1. The result is taken as the upper 32 bits of index·M' when the flag field equals 1 the product is instead (index+1)·M'; and that result is then shifted right by s. No shift is applied before the multiply. Constants prepared as floor(log2 d), ceil(2^(s+32)/d), with round-down (multiplier minus one, flag 1) when 2^(s+32) mod d ≤ 2^s, give exactly floor(index/d).
- R5: Bit 31 of the supplied multiplier has no effect on any result: the same request with that bit cleared or set yields the same output.
- R6: A request accepted at a rising edge with out_ready held high appears on the output (out_valid high) after the third rising edge, counting the edge of acceptance as the first.
- R7: While out_valid is high and out_ready is low, out_valid and out_index hold their values and in_ready is low. When out_valid is low or out_ready is high, in_ready is high. Results leave in acceptance order, with none lost or duplicated.
- R8: While rst is high at a rising edge, the pipeline empties: out_valid is low and in_ready is high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted at the next edge when in_valid is high |
| in_index | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 direct, 1 modulo, 2 power-of-two divide, 3 multiplier divide |
| in_shift | input | 5 | Power-of-two exponent or post-shift amount |
| in_xflags | input | 3 | Odd-factor selector in mode 1; round-down enable (value 1) in mode 3 |
| in_magic | input | 32 | Multiplier for mode 3; bit 31 is ignored |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at the next edge |
| out_index | output | 32 | Attribute element index |

## Verification
A request that is accepted at edge k has its result on the output after edge k+2. It is therefore first seen by the handshake evaluation in the cycle that ends at edge k+3. The bench evaluates both handshakes one nanosecond after each falling edge. This is where the values the next rising edge will see are already settled. The bench stamps every accepted request with its cycle number, and while out_ready is held high it requires the result exactly three cycles later. Under random back-pressure, results are matched only when a handshake occurs, in acceptance order. Each stalled cycle is followed by a check that the held output did not change.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;
   localparam int MODE_W     = 2;
   localparam int PIPE_DEPTH = 3;

   typedef enum logic [MODE_W-1:0] {
      AM_DIRECT = 2'd0,
      AM_MODULO = 2'd1,
      AM_SHIFT  = 2'd2,
      AM_MAGIC  = 2'd3
   } amode_e;
endpackage

// File: rtl/aig_pipe_ctl.sv
module aig_pipe_ctl #(
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             out_ready,
   output logic             adv,
   output logic             in_ready,
   output logic [DEPTH-1:0] vld
);
   // lockstep pipeline: every stage moves when the last one can drain
   assign adv      = !vld[DEPTH-1] || out_ready;
   assign in_ready = adv;

   always_ff @(posedge clk) begin
      if (rst)      vld[0] <= 1'b0;
      else if (adv) vld[0] <= in_valid;
   end

   for (genvar k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)      vld[k] <= 1'b0;
         else if (adv) vld[k] <= vld[k-1];
      end
   end
endmodule

// File: rtl/aig_mul_hi.sv
module aig_mul_hi #(
   parameter int W = 32
) (
   input  logic [W-1:0] idx,
   input  logic [W-1:0] mult,
   input  logic         round_dn,
   output logic [W-1:0] hi
);
   localparam int AW = 2 * W + 1;

   logic [W-1:0]  meff;
   logic [AW-1:0] acc;
   logic          lint_unused;

   // top bit of the multiplier is implied, whatever was supplied
   assign meff = {1'b1, mult[W-2:0]};

   // (idx + 1) * M folded into one adder as idx*M + M
   assign acc = {{(W+1){1'b0}}, idx} * {{(W+1){1'b0}}, meff}
              + {{(W+1){1'b0}}, (round_dn ? meff : {W{1'b0}})};

   assign hi = acc[2*W-1:W];

   assign lint_unused = mult[W-1] ^ acc[AW-1] ^ (^acc[W-1:0]);
endmodule

// File: rtl/aig_odd_mod.sv
module aig_odd_mod #(
   parameter int W   = 32,
   parameter int M_W = 3
) (
   input  logic [W-1:0]   q,
   input  logic [M_W-1:0] m,
   output logic [W-1:0]   r
);
   localparam int NODD = 1 << M_W;

   logic [W-1:0] cand [NODD];

   // one constant-divisor residue unit per odd factor 2k+1
   for (genvar k = 0; k < NODD; k++) begin : g_odd
      localparam logic [W-1:0] ODD = W'(2 * k + 1);
      assign cand[k] = q % ODD;
   end

   assign r = cand[m];
endmodule

// File: rtl/attr_index_gen.sv
module attr_index_gen
   import attr_idx_pkg::*;
#(
   parameter int IDX_W = 32,
   parameter int SH_W  = $clog2(IDX_W),
   parameter int XF_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [IDX_W-1:0]  in_index,
   input  logic [MODE_W-1:0] in_mode,
   input  logic [SH_W-1:0]   in_shift,
   input  logic [XF_W-1:0]   in_xflags,
   input  logic [IDX_W-1:0]  in_magic,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IDX_W-1:0]  out_index
);
   localparam logic [IDX_W-1:0] ONES = {IDX_W{1'b1}};

   if (IDX_W < 8 || (IDX_W & (IDX_W - 1)) != 0) begin : g_bad_w
      $error("IDX_W must be a power of two of at least 8");
   end
   if (SH_W != $clog2(IDX_W)) begin : g_bad_sh
      $error("SH_W must equal clog2(IDX_W)");
   end
   if (PIPE_DEPTH != 3) begin : g_bad_depth
      $error("datapath is laid out for three stages");
   end

   logic                  adv;
   logic [PIPE_DEPTH-1:0] vld;

   aig_pipe_ctl #(.DEPTH(PIPE_DEPTH)) u_ctl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .adv       (adv),
      .in_ready  (in_ready),
      .vld       (vld)
   );

   assign out_valid = vld[PIPE_DEPTH-1];

   // ---------------- stage 1: capture ----------------
   logic [IDX_W-1:0] s1_idx, s1_mag;
   amode_e           s1_mode;
   logic [SH_W-1:0]  s1_sh;
   logic [XF_W-1:0]  s1_xf;

   always_ff @(posedge clk) begin
      if (adv) begin
         s1_idx  <= in_index;
         s1_mode <= amode_e'(in_mode);
         s1_sh   <= in_shift;
         s1_xf   <= in_xflags;
         s1_mag  <= in_magic;
      end
   end

   // ---------------- stage 2: multiply / split ----------------
   logic [IDX_W-1:0] mul_hi, s2_nx;
   logic             rd_en;

   assign rd_en = (s1_mode == AM_MAGIC) && (s1_xf == XF_W'(1));

   aig_mul_hi #(.W(IDX_W)) u_mul (
      .idx      (s1_idx),
      .mult     (s1_mag),
      .round_dn (rd_en),
      .hi       (mul_hi)
   );

   always_comb begin
      unique case (s1_mode)
         AM_DIRECT: s2_nx = s1_idx;
         AM_MAGIC:  s2_nx = mul_hi;
         default:   s2_nx = s1_idx >> s1_sh;
      endcase
   end

   logic [IDX_W-1:0] s2_val, s2_low;
   amode_e           s2_mode;
   logic [SH_W-1:0]  s2_sh;
   logic [XF_W-1:0]  s2_xf;

   always_ff @(posedge clk) begin
      if (adv) begin
         s2_val  <= s2_nx;
         s2_low  <= s1_idx & ~(ONES << s1_sh);
         s2_mode <= s1_mode;
         s2_sh   <= s1_sh;
         s2_xf   <= s1_xf;
      end
   end

   // ---------------- stage 3: residue / post-shift ----------------
   logic [IDX_W-1:0] mod_r, out_nx;

   aig_odd_mod #(.W(IDX_W), .M_W(XF_W)) u_mod (
      .q (s2_val),
      .m (s2_xf),
      .r (mod_r)
   );

   always_comb begin
      unique case (s2_mode)
         AM_MODULO: out_nx = (mod_r << s2_sh) | s2_low;
         AM_MAGIC:  out_nx = s2_val >> s2_sh;
         default:   out_nx = s2_val;
      endcase
   end

   always_ff @(posedge clk) begin
      if (adv) out_index <= out_nx;
   end
endmodule

// File: rtl/attr_index_gen_chk.sv
module attr_index_gen_chk
   import attr_idx_pkg::*;
#(
   parameter int IDX_W = 32,
   parameter int SH_W  = $clog2(IDX_W),
   parameter int XF_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic [IDX_W-1:0]  in_index,
   input logic [MODE_W-1:0] in_mode,
   input logic [SH_W-1:0]   in_shift,
   input logic [XF_W-1:0]   in_xflags,
   input logic [IDX_W-1:0]  in_magic,
   input logic              out_valid,
   input logic              out_ready,
   input logic [IDX_W-1:0]  out_index
);
   localparam int D = PIPE_DEPTH;

   logic                  go;
   logic [D-1:0]          sv;
   logic [IDX_W-1:0]      six [D];
   logic [MODE_W-1:0]     smd [D];
   logic [SH_W-1:0]       ssh [D];
   logic [XF_W-1:0]       sxf [D];
   logic                  lint_unused;

   assign go          = !out_valid || out_ready;
   assign lint_unused = ^in_magic;

   always_ff @(posedge clk) begin
      if (rst)     sv <= '0;
      else if (go) sv <= {sv[D-2:0], in_valid && in_ready};
   end

   always_ff @(posedge clk) begin
      if (go) begin
         six[0] <= in_index;
         smd[0] <= in_mode;
         ssh[0] <= in_shift;
         sxf[0] <= in_xflags;
         for (int k = 1; k < D; k++) begin
            six[k] <= six[k-1];
            smd[k] <= smd[k-1];
            ssh[k] <= ssh[k-1];
            sxf[k] <= sxf[k-1];
         end
      end
   end

   a_r6_valid_timing: assert property (@(posedge clk) disable iff (rst)
      out_valid == sv[D-1]);

   a_r1_direct: assert property (@(posedge clk) disable iff (rst)
      (out_valid && smd[D-1] == 2'd0) |-> out_index == six[D-1]);

   a_r3_shift: assert property (@(posedge clk) disable iff (rst)
      (out_valid && smd[D-1] == 2'd2) |-> out_index == (six[D-1] >> ssh[D-1]));

   a_r2_low_bits: assert property (@(posedge clk) disable iff (rst)
      (out_valid && smd[D-1] == 2'd1) |->
      ((out_index ^ six[D-1]) & ~({IDX_W{1'b1}} << ssh[D-1])) == '0);

   a_r2_range: assert property (@(posedge clk) disable iff (rst)
      (out_valid && smd[D-1] == 2'd1) |->
      (out_index >> ssh[D-1]) < IDX_W'({sxf[D-1], 1'b1}));

   a_r4_bound: assert property (@(posedge clk) disable iff (rst)
      (out_valid && smd[D-1] == 2'd3) |-> out_index <= six[D-1]);

   a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_index)));

   a_r8_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready));
endmodule

bind attr_index_gen attr_index_gen_chk #(
   .IDX_W (IDX_W),
   .SH_W  (SH_W),
   .XF_W  (XF_W)
) u_chk (.*);

// File: tb/sim_attr_index_gen.sv
module sim_attr_index_gen;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_index = '0;
   logic [1:0]  in_mode = '0;
   logic [4:0]  in_shift = '0;
   logic [2:0]  in_xflags = '0;
   logic [31:0] in_magic = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_index;

   always #2 clk = ~clk;

   attr_index_gen u0 (
      .clk (clk), .rst (rst),
      .in_valid (in_valid), .in_ready (in_ready),
      .in_index (in_index), .in_mode (in_mode), .in_shift (in_shift),
      .in_xflags (in_xflags), .in_magic (in_magic),
      .out_valid (out_valid), .out_ready (out_ready), .out_index (out_index)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // pending stimulus
   logic [31:0] st_idx [$];
   logic [1:0]  st_md  [$];
   logic [4:0]  st_sh  [$];
   logic [2:0]  st_xf  [$];
   logic [31:0] st_mag [$];
   logic [31:0] st_exp [$];
   string       st_tag [$];
   // accepted, awaiting result
   logic [31:0] ex_val [$];
   string       ex_tag [$];
   int          ex_cyc [$];

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic add(logic [31:0] idx, logic [1:0] md, logic [4:0] sh, logic [2:0] xf,
                      logic [31:0] mag, logic [31:0] exp, string tag);
      st_idx.push_back(idx); st_md.push_back(md); st_sh.push_back(sh);
      st_xf.push_back(xf); st_mag.push_back(mag); st_exp.push_back(exp);
      st_tag.push_back(tag);
   endtask

   // mode 3 from the requirement text (raw multiplier)
   function automatic logic [31:0] magic_ref(logic [31:0] idx, logic [31:0] mag,
                                            logic [2:0] xf, logic [4:0] sh);
      bit [63:0] mm, p;
      mm = {32'd0, 1'b1, mag[30:0]};
      p  = {32'd0, idx} * mm;
      if (xf == 3'd1) p = p + mm;
      return p[63:32] >> sh;
   endfunction

   // constant preparation for a divisor d
   task automatic prep(logic [31:0] d, output logic [31:0] mag, output logic [4:0] sh,
                       output logic [2:0] xf);
      int s = 0;
      bit [63:0] num, m, e;
      for (int i = 0; i < 32; i++) if (d[i]) s = i;
      num = 64'd1 << (s + 32);
      m   = num / {32'd0, d};
      e   = num % {32'd0, d};
      if (e != 0) m = m + 1;
      if (e <= (64'd1 << s)) begin mag = 32'(m - 1); xf = 3'd1; end
      else                   begin mag = 32'(m);     xf = 3'd0; end
      sh = 5'(s);
   endtask

   task automatic load_set();
      logic [31:0] dl [10];
      // R1 direct
      add(32'h0, 2'd0, 5'd7, 3'd2, 32'h0, 32'h0, "R1");
      add(32'hFFFF_FFFF, 2'd0, 5'd31, 3'd7, $urandom, 32'hFFFF_FFFF, "R1");
      for (int i = 0; i < 6; i++) begin
         logic [31:0] v = $urandom;
         add(v, 2'd0, 5'($urandom), 3'($urandom), $urandom, v, "R1");
      end
      // R2 modulo, every odd factor
      for (int m = 0; m < 8; m++) begin
         logic [4:0] shl [5];
         shl = '{5'd0, 5'd1, 5'd3, 5'd31, 5'($urandom)};
         for (int j = 0; j < 5; j++) begin
            bit [63:0] d = 64'(2 * m + 1) << shl[j];
            logic [31:0] ids [4];
            ids = '{32'h0, 32'hFFFF_FFFF, $urandom, $urandom & 32'h0000_FFFF};
            for (int t = 0; t < 4; t++)
               add(ids[t], 2'd1, shl[j], 3'(m), $urandom, 32'({32'd0, ids[t]} % d), "R2");
            if (d <= 64'hFFFF_FFFF) begin
               add(32'(d - 1), 2'd1, shl[j], 3'(m), 32'h0, 32'(d - 1), "R2");
               add(32'(d), 2'd1, shl[j], 3'(m), 32'h0, 32'h0, "R2");
            end
         end
      end
      add(32'd70, 2'd1, 5'd3, 3'd4, 32'h0, 32'd70, "R2");
      add(32'd72, 2'd1, 5'd3, 3'd4, 32'h0, 32'd0, "R2");
      add(32'd145, 2'd1, 5'd3, 3'd4, 32'h0, 32'd1, "R2");
      // R3 power-of-two divide
      for (int s = 0; s < 32; s++) begin
         logic [31:0] v = $urandom;
         add(v, 2'd3 - 2'd1, 5'(s), 3'($urandom), $urandom, v >> s, "R3");
      end
      add(32'hFFFF_FFFF, 2'd2, 5'd31, 3'd0, 32'h0, 32'h1, "R3");
      // R4 / R5 divisor constants, true floor division
      dl = '{32'd3, 32'd5, 32'd7, 32'd9, 32'd72, 32'd1, 32'd2,
             32'hFFFF_FFFF, 32'h8000_0000, ($urandom | 32'd1)};
      for (int k = 0; k < 10; k++) begin
         logic [31:0] mag; logic [4:0] sh; logic [2:0] xf;
         logic [31:0] ids [5];
         prep(dl[k], mag, sh, xf);
         ids = '{32'h0, 32'hFFFF_FFFF, dl[k] - 32'd1, dl[k], $urandom};
         for (int t = 0; t < 5; t++) begin
            add(ids[t], 2'd3, sh, xf, mag | 32'h8000_0000, ids[t] / dl[k], "R4");
            add(ids[t], 2'd3, sh, xf, mag & 32'h7FFF_FFFF, ids[t] / dl[k], "R5");
         end
      end
      // R4 raw multiplier, every flag value
      for (int i = 0; i < 24; i++) begin
         logic [31:0] v = $urandom, mg = $urandom;
         logic [4:0] sh = 5'($urandom);
         logic [2:0] xf = 3'(i % 8);
         add(v, 2'd3, sh, xf, mg, magic_ref(v, mg, xf, sh), "R4");
      end
   endtask

   task automatic run_phase(bit random_flow);
      int  cyc = 0;
      bit  prev_stall = 0;
      logic [31:0] prev_out = '0;
      while (st_idx.size() != 0 || ex_val.size() != 0) begin
         @(negedge clk);
         out_ready = random_flow ? ($urandom % 4 != 0) : 1'b1;
         if (st_idx.size() != 0 && (!random_flow || $urandom % 3 != 0)) begin
            in_valid  = 1'b1;
            in_index  = st_idx[0]; in_mode = st_md[0]; in_shift = st_sh[0];
            in_xflags = st_xf[0];  in_magic = st_mag[0];
         end else begin
            in_valid  = 1'b0;
            in_index  = $urandom;
         end
         #1;
         if (prev_stall)
            chk(out_valid && out_index == prev_out, "R7", "held output", out_index, prev_out);
         chk(in_ready == (!out_valid || out_ready), "R7", "in_ready",
             32'(in_ready), 32'(!out_valid || out_ready));
         if (out_valid && out_ready) begin
            if (ex_val.size() == 0) begin
               chk(1'b0, "R7", "result with nothing pending", out_index, 32'hx);
            end else begin
               logic [31:0] e = ex_val.pop_front();
               string       tg = ex_tag.pop_front();
               int          c0 = ex_cyc.pop_front();
               chk(out_index == e, tg, "result", out_index, e);
               if (!random_flow)
                  chk(cyc - c0 == 3, "R6", "latency", 32'(cyc - c0), 32'd3);
            end
         end
         if (in_valid && in_ready) begin
            ex_val.push_back(st_exp.pop_front());
            ex_tag.push_back(st_tag.pop_front());
            ex_cyc.push_back(cyc);
            void'(st_idx.pop_front()); void'(st_md.pop_front());
            void'(st_sh.pop_front());  void'(st_xf.pop_front());
            void'(st_mag.pop_front());
         end
         prev_stall = out_valid && !out_ready;
         prev_out   = out_index;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!out_valid, "R8", "out_valid after reset", 32'(out_valid), 32'd0);
      chk(in_ready, "R8", "in_ready after reset", 32'(in_ready), 32'd1);
      load_set();
      run_phase(1'b0);
      load_set();
      run_phase(1'b1);
      // reset while results are in flight empties the pipe
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b1; in_mode = 2'd0; in_index = 32'h1234;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!out_valid, "R8", "out_valid after mid-run reset", 32'(out_valid), 32'd0);
      chk(in_ready, "R8", "in_ready after mid-run reset", 32'(in_ready), 32'd1);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, got %0d pending expected 0", ex_val.size());
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule